// File: doc/BRIEF.md
# Transparent-or-Clocked Parity Word Holding Stage

This block is a one-direction holding stage for a word made of byte lanes, each lane carrying eight data bits and one parity bit (two lanes, eighteen bits by default). A level-sensitive pass control and an edge-sensitive capture strobe select how the word moves through it. While pass is high, the stage is transparent and the output tracks the input combinationally. While pass is low, the stage only loads on a rising edge of the capture strobe, and otherwise it holds what it has.

The capture strobe is treated as a slow control signal. It is sampled on the system clock, and its rising edge is detected there. A single stored word serves both modes. It is rewritten on every system clock while the stage is transparent. That is why a strobe edge that happened during transparency causes no extra load later, while a strobe that was low when pass fell still loads on its next rise.

An active-low output enable stands in for a tri-state driver. When it is high, every bit's drive flag is clear and the data output reads zero. The stored word is untouched by the output enable. The stage computes no parity: parity bits travel with their bytes unchanged.

Top module: `dual_mode_hold_stage`

## Requirements
- R1: A system clock edge with `rst_n` low clears the stored word to all zeros. After reset, with pass low, the enabled output reads zero.
- R2: While `pass_i` is high, `word_o` equals `word_i` in the same cycle. The stored word takes the value `word_i` had at each system clock edge.
- R3: While `pass_i` is low, a system clock edge at which `strobe_i` is 1 and was 0 at the previous edge loads `word_i` into the stored word. The output shows it from the next cycle.
- R4: While `pass_i` is low and no rising strobe edge is seen, the output holds its value whatever `word_i` does. This holds whether the strobe stays high or stays low.
- R5: While `oe_n_i` is 1, every bit of `drive_o` is 0 and `word_o` is zero. While it is 0, every bit of `drive_o` is 1. The output enable changes neither loading nor the stored word.
- R6: Word layout is fixed. Byte k occupies bits [8k+7:8k] and its parity bit sits at bit 16+k. All eighteen bits, including parity that does not match its byte, pass through unmodified.
- R7: Suppose the strobe rose while pass was high and is still high when pass falls. Then the stage keeps the last transparent value, and it does not load again until the strobe goes low and rises again.
- R8: Suppose the strobe is low when pass falls. Then the stage keeps the last transparent value only until the next rising strobe edge, which replaces it with the input present at that edge.
- R9: A strobe held high across reset release does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_i | input | 1 | High: transparent; low: hold or edge capture |
| strobe_i | input | 1 | Capture strobe, rising edge loads while pass is low |
| oe_n_i | input | 1 | Active-low output enable |
| word_i | input | 18 | Input word: data bytes in [15:0], parity bits in [17:16] |
| word_o | output | 18 | Output word, zero while disabled |
| drive_o | output | 18 | Per-bit drive-enable flags |

## Verification
The bench aims at the moment pass falls, with the strobe on each side of it. A design that kept its own separate edge flop would reload after a strobe edge seen during transparency, breaking R7. A design that latched only on the falling edge of pass would miss the later strobe rise of R8. It also holds the strobe high through reset release, where an edge detector that resets to zero would load a spurious word. It checks that a disabled output still lets the word be stored, and that parity which does not match its byte comes out unchanged.

// File: rtl/hold_stage_pkg.sv
`timescale 1ns/1ps
package hold_stage_pkg;

   typedef enum logic [1:0] {
      LD_CLEAR   = 2'd0,
      LD_PASS    = 2'd1,
      LD_CAPTURE = 2'd2,
      LD_KEEP    = 2'd3
   } load_kind_e;

   // Reset wins over everything, transparency over the strobe edge.
   function automatic load_kind_e pick_load(input logic rst_n,
                                            input logic pass,
                                            input logic rise);
      if (!rst_n)     return LD_CLEAR;
      else if (pass)  return LD_PASS;
      else if (rise)  return LD_CAPTURE;
      else            return LD_KEEP;
   endfunction

endpackage

// File: rtl/strobe_rise_detect.sv
`timescale 1ns/1ps
module strobe_rise_detect #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic rise_o
);
   logic seen;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign seen = strobe_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], strobe_i} ;
         end
         assign seen = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // Previous sample resets high so a strobe already high at release is no edge.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= seen;
   end

   assign rise_o = seen & ~prev_q;

   AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);  // R4
   AST_NO_RISE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rise_o);  // R9

endmodule

// File: rtl/lane_store.sv
`timescale 1ns/1ps
module lane_store
   import hold_stage_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  load_kind_e        kind_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_i,
   output logic [DATA_W-1:0] data_q,
   output logic              par_q
);
   always_ff @(posedge clk) begin
      unique case (kind_i)
         LD_CLEAR: begin
            data_q <= '0;
            par_q  <= 1'b0;
         end
         LD_PASS, LD_CAPTURE: begin
            data_q <= data_i;
            par_q  <= par_i;
         end
         default: begin
            data_q <= data_q;
            par_q  <= par_q;
         end
      endcase
   end

   AST_CLEARED_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (data_q == '0 && !par_q));  // R1
   AST_PASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == LD_PASS) |=> (data_q == $past(data_i) && par_q == $past(par_i)));  // R2
   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == LD_CAPTURE) |=> (data_q == $past(data_i)));  // R3
   AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == LD_KEEP) |=> ($stable(data_q) && $stable(par_q)));  // R4

endmodule

// File: rtl/drive_gate.sv
`timescale 1ns/1ps
module drive_gate #(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oe_n_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o,
   output logic [WORD_W-1:0] drive_o
);
   always_comb begin
      drive_o = {WORD_W{~oe_n_i}};
      word_o  = oe_n_i ? '0 : word_i;
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> (drive_o == '0 && word_o == '0));  // R5
   AST_ON_ALL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_i |-> (&drive_o && word_o == word_i));  // R5

endmodule

// File: rtl/dual_mode_hold_stage.sv
`timescale 1ns/1ps
module dual_mode_hold_stage
   import hold_stage_pkg::*;
#(
   parameter int LANES       = 2,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pass_i,
   input  logic                           strobe_i,
   input  logic                           oe_n_i,
   input  logic [LANES*(BYTE_W+1)-1:0]    word_i,
   output logic [LANES*(BYTE_W+1)-1:0]    word_o,
   output logic [LANES*(BYTE_W+1)-1:0]    drive_o
);
   localparam int DATA_BITS = LANES * BYTE_W;
   localparam int WORD_W    = LANES * (BYTE_W + 1);

   generate
      if (LANES < 1)       begin : g_bad_lanes  $error("LANES must be at least 1");       end
      if (BYTE_W < 1)      begin : g_bad_byte   $error("BYTE_W must be at least 1");      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3)
                           begin : g_bad_sync   $error("SYNC_STAGES must be 0 to 3");     end
   endgenerate

   logic        rise;
   load_kind_e  kind;
   logic [WORD_W-1:0] stored;
   logic [WORD_W-1:0] visible;

   strobe_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rise (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .rise_o   (rise)
   );

   assign kind = pick_load(rst_n, pass_i, rise);

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         lane_store #(.DATA_W(BYTE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .kind_i (kind),
            .data_i (word_i[k*BYTE_W +: BYTE_W]),
            .par_i  (word_i[DATA_BITS + k]),
            .data_q (stored[k*BYTE_W +: BYTE_W]),
            .par_q  (stored[DATA_BITS + k])
         );
      end
   endgenerate

   // Transparent path bypasses the store; held path shows it.
   assign visible = pass_i ? word_i : stored;

   drive_gate #(.WORD_W(WORD_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_n_i  (oe_n_i),
      .word_i  (visible),
      .word_o  (word_o),
      .drive_o (drive_o)
   );

   AST_PASS_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_i && !oe_n_i) |-> (word_o == word_i));  // R2
   AST_HELD_OUTPUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_i && !rise && !oe_n_i) ##1 (!pass_i && !oe_n_i) |-> $stable(word_o));  // R4

endmodule

// File: tb/sim_dual_mode_hold_stage.sv
`timescale 1ns/1ps
module sim_dual_mode_hold_stage;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pass = 1'b0;
   logic strobe = 1'b0;
   logic oe_n = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   logic [W-1:0] drv;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   // Behavioural reference state
   logic [W-1:0] m_store = '0;
   logic         m_prev  = 1'b1;

   always #5 clk = ~clk;

   dual_mode_hold_stage u0 (
      .clk(clk), .rst_n(rst_n), .pass_i(pass), .strobe_i(strobe),
      .oe_n_i(oe_n), .word_i(din), .word_o(dout), .drive_o(drv)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_store = '0;
         m_prev  = 1'b1;
      end else begin
         if (pass)                  m_store = din;
         else if (strobe && !m_prev) m_store = din;
         m_prev = strobe;
      end
   end

   task automatic compare(input string tag);
      logic [W-1:0] exp_d, exp_e;
      exp_e = oe_n ? '0 : '1;
      exp_d = oe_n ? '0 : (pass ? din : m_store);
      checks++;
      if (dout !== exp_d || drv !== exp_e) begin
         bad++;
         $display("FAIL %s: word_o=%h drive_o=%h expected word_o=%h drive_o=%h",
                  tag, dout, drv, exp_d, exp_e);
      end
   endtask

   task automatic step(input logic r, input logic p, input logic s,
                       input logic oe, input logic [W-1:0] d, input string tag);
      @(negedge clk);
      rst_n = r; pass = p; strobe = s; oe_n = oe; din = d;
      #2;
      compare(tag);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      // R1 / R9: reset with strobe high, release with strobe still high
      step(0, 0, 1, 0, 18'h2ABCD, "R1");
      step(0, 0, 1, 0, 18'h15555, "R1");
      step(1, 0, 1, 0, 18'h3FFFF, "R9");
      step(1, 0, 1, 0, 18'h12345, "R9");
      step(1, 0, 1, 0, 18'h0F0F0, "R9");

      // R2: transparent under several patterns
      step(1, 1, 0, 0, 18'h3FFFF, "R2");
      step(1, 1, 0, 0, 18'h00000, "R2");
      step(1, 1, 0, 0, 18'h2A5A5, "R2");
      step(1, 1, 0, 0, 18'h15A5A, "R2");

      // R7: strobe rises during transparency, pass falls with strobe high
      step(1, 1, 1, 0, 18'h0AAAA, "R7");
      step(1, 0, 1, 0, 18'h3BEEF, "R7");
      step(1, 0, 1, 0, 18'h11111, "R7");
      step(1, 0, 1, 0, 18'h22222, "R4");
      step(1, 0, 0, 0, 18'h33333, "R4");
      step(1, 0, 0, 0, 18'h04444, "R4");
      step(1, 0, 1, 0, 18'h1C0DE, "R3");
      step(1, 0, 1, 0, 18'h25555, "R3");
      step(1, 0, 1, 0, 18'h36666, "R4");

      // R8: pass falls with strobe low; next rise replaces held word
      step(1, 1, 0, 0, 18'h0E0E0, "R8");
      step(1, 0, 0, 0, 18'h1F1F1, "R8");
      step(1, 0, 0, 0, 18'h2D2D2, "R8");
      step(1, 0, 1, 0, 18'h3C3C3, "R8");
      step(1, 0, 1, 0, 18'h01010, "R8");
      if (m_store !== 18'h3C3C3) begin
         bad++;
         $display("FAIL R8: model word=%h expected=%h", m_store, 18'h3C3C3);
      end
      checks++;

      // R6: mismatched parity and byte placement pass through unchanged
      step(1, 0, 0, 0, 18'h201FE, "R6");
      step(1, 0, 1, 0, 18'h201FE, "R6");
      step(1, 0, 1, 0, 18'h00000, "R6");
      checks++;
      if (dout[17:16] !== 2'b10 || dout[15:8] !== 8'h01 || dout[7:0] !== 8'hFE) begin
         bad++;
         $display("FAIL R6: word_o=%h expected=%h", dout, 18'h201FE);
      end

      // R5: disabled output, storage still loads underneath
      step(1, 1, 0, 1, 18'h3ABCD, "R5");
      step(1, 0, 0, 1, 18'h1234F, "R5");
      step(1, 0, 1, 1, 18'h2FEDC, "R5");
      step(1, 0, 1, 0, 18'h00001, "R5");
      checks++;
      if (dout !== 18'h2FEDC) begin
         bad++;
         $display("FAIL R5: word_o=%h expected=%h", dout, 18'h2FEDC);
      end

      // R1: reset mid-run clears the stored word
      step(0, 0, 0, 0, 18'h3FFFF, "R1");
      step(1, 0, 0, 0, 18'h3FFFF, "R1");

      // Mixed random traffic against the model
      for (int i = 0; i < 300; i++) begin
         step(1, ($urandom % 4) == 0, $urandom % 2, ($urandom % 8) == 0,
              W'($urandom), "R3");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule